// File: doc/BRIEF.md
# PWM Compare Channel with Asynchronous Fault Shutdown

This block is one pulse-width-modulated output channel. An internal up-counter advances on each prescaled `tick` strobe and wraps to zero after it reaches the programmed period value. The output is high while the count is below the active duty value and low for the rest of the period. Software writes the next duty value into a shadow register at any moment. That value is copied into the active register only at the end of a period, so a period never mixes an old duty value with a new one.

An active-low fault input gates the pad output-enable combinationally. The pad cell then goes to high impedance at once, with no clock edge needed. A two-flop synchronised copy of the fault input latches a shutdown state, a read-only status bit and a sticky interrupt flag. The shutdown stays in force until the fault input is high again and software rewrites the mode field. The channel runs only when the 3-bit mode field holds 3'b111. All control goes through a small register port with a write strobe, an address, and a combinational read mux. There is no data stream, so every pin is plain control or status.

Top module: `pwm_fault_channel`

## Requirements
- R1: The channel runs only when the mode field (register 0, bits 2:0) equals 3'b111. In any other mode `pwm_oe` and `pwm_out` are 0.
- R2: With period value P (register 1), the counter counts 0..P on `tick` and then wraps to 0, so the output repeats every P+1 ticks.
- R3: A write to register 2 loads only the duty shadow. The active duty, which register 2 reads back, changes only on the tick where the count equals or exceeds P. Software cannot write the active duty directly.
- R4: An active duty of 0 holds `pwm_out` low for the whole period.
- R5: An active duty greater than P holds `pwm_out` high for the whole period.
- R6: An active duty equal to P gives exactly one low count per period.
- R7: `pwm_out` is high exactly while the count is below the active duty. Over k whole periods it is high for k·min(D, P+1) ticks.
- R8: While `fault_n` is 0, `pwm_oe` is 0 in the same time step, with no clock edge needed.
- R9: In PWM mode a synchronised fault latches a shutdown that keeps `pwm_oe` at 0 after `fault_n` returns high. A write to register 0 clears it only if the fault is gone at that time. A write made while the fault is still present does not clear it.
- R10: The fault status bit (register 0, bit 3) is set by the latched shutdown and clears together with it.
- R11: A latched fault sets the interrupt flag (`irq`, register 3 bit 0). Writing 1 to register 3 bit 0 clears the flag. Writing 0 there has no effect.
- R12: A fault while the mode is not 3'b111 sets neither the status bit nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled time-base advance strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Combinational read data |
| fault_n | input | 1 | Active-low fault input |
| pwm_out | output | 1 | PWM level to the pad |
| pwm_oe | output | 1 | Pad output enable (0 = high impedance) |
| irq | output | 1 | Sticky fault interrupt flag |

## Verification
The bench checks the three duty edge cases: zero, equal to the period, and above the period. A compare that used `<=`, or one that did not saturate, would show one extra or one missing high count in each period. It stops the time base while writing the shadow register. A design that loaded the active register straight away would show the new value before the period ends. It checks that the enable drops between clock edges once the fault pin falls, which catches a design that only samples the fault on a clock. It also clears the shutdown both with the fault still present and with the fault removed, and confirms that the shutdown holds in the first case and releases in the second.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
  localparam int ADDR_W = 2;
  localparam logic [2:0] MODE_PWM_FAULT = 3'b111;
  localparam int STATUS_BIT = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE   = 2'd0,
    REG_PERIOD = 2'd1,
    REG_DUTY   = 2'd2,
    REG_FLAG   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic at_end;
  assign at_end = (count >= period);
  assign wrap   = tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (wrap) count <= '0;
    else if (tick) count <= count + 1'b1;
  end

  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0))
    else $error("counter did not wrap");
  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !at_end) |=> (count == $past(count) + 1'b1))
    else $error("counter did not step");
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count))
    else $error("counter moved without tick");
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic             shadow_wr,
  input  logic [CNT_W-1:0] shadow_in,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] active,
  output logic             level
);
  logic [CNT_W-1:0] shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow <= '0;
    else if (shadow_wr) shadow <= shadow_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    active <= '0;
    else if (wrap) active <= shadow;
  end

  assign level = (count < active);

  assert_active_only_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(active))
    else $error("active duty changed mid-period");
  assert_active_takes_shadow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (active == $past(shadow)))
    else $error("active duty missed shadow");
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_n,
  input  logic enabled,
  input  logic mode_wr,
  input  logic flag_clr,
  output logic latched,
  output logic flag
);
  logic sync1, sync2, seen, set_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= fault_n;
      sync2 <= sync1;
    end
  end

  assign seen    = !sync2;
  assign set_evt = enabled && seen && !latched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                latched <= 1'b0;
    else if (set_evt)          latched <= 1'b1;
    else if (mode_wr && !seen) latched <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (set_evt)  flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  assert_latch_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !mode_wr) |=> latched)
    else $error("fault latch released without mode write");
  assert_latch_needs_clear_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && seen) |=> latched)
    else $error("fault latch released while fault present");
  assert_flag_on_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> (flag && latched))
    else $error("fault did not raise flag");
  assert_no_set_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && !latched) |=> !latched)
    else $error("fault latched outside PWM mode");
endmodule

// File: rtl/pwm_fault_channel.sv
module pwm_fault_channel
  import pwm_fault_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [CNT_W-1:0]    rd_data,
  input  logic                fault_n,
  output logic                pwm_out,
  output logic                pwm_oe,
  output logic                irq
);
  logic [2:0]       mode;
  logic [CNT_W-1:0] period, count, active;
  logic             wrap, level, latched, enabled;
  logic             mode_wr, period_wr, duty_wr, flag_clr;

  assign mode_wr   = wr_en && (wr_addr == REG_MODE);
  assign period_wr = wr_en && (wr_addr == REG_PERIOD);
  assign duty_wr   = wr_en && (wr_addr == REG_DUTY);
  assign flag_clr  = wr_en && (wr_addr == REG_FLAG) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= '0;
      period <= PERIOD_RST;
    end else begin
      if (mode_wr)   mode   <= wr_data[2:0];
      if (period_wr) period <= wr_data;
    end
  end

  assign enabled = (mode == MODE_PWM_FAULT);

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period(period),
    .count(count), .wrap(wrap)
  );

  pwm_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .shadow_wr(duty_wr),
    .shadow_in(wr_data), .count(count), .active(active), .level(level)
  );

  pwm_fault_guard u_flt (
    .clk(clk), .rst_n(rst_n), .fault_n(fault_n), .enabled(enabled),
    .mode_wr(mode_wr), .flag_clr(flag_clr), .latched(latched), .flag(irq)
  );

  assign pwm_out = enabled && level;
  assign pwm_oe  = enabled && fault_n && !latched;

  always_comb begin
    rd_data = '0;
    case (reg_sel_e'(rd_addr))
      REG_MODE: begin
        rd_data[2:0]       = mode;
        rd_data[STATUS_BIT] = latched;
      end
      REG_PERIOD: rd_data = period;
      REG_DUTY:   rd_data = active;
      REG_FLAG:   rd_data[0] = irq;
      default:    rd_data = '0;
    endcase
  end

  always_comb begin
    if (rst_n && !fault_n)
      assert_fault_hiz_R8: assert (!pwm_oe) else $error("output enabled during fault");
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> (!pwm_out && !pwm_oe))
    else $error("output active outside PWM mode");
  assert_zero_duty_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> !pwm_out)
    else $error("zero duty drove high");
  assert_full_duty_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && active > period && count <= period) |-> pwm_out)
    else $error("over-period duty went low");
endmodule

// File: tb/pwm_fault_channel_tb_top.sv
module pwm_fault_channel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, fault_n = 1;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [W-1:0] wr_data = '0, rd_data;
  logic pwm_out, pwm_oe, irq;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_fault_channel #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .fault_n(fault_n),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); h += int'(pwm_out); end
  endtask

  task automatic set_duty(input int p, input int d);
    logic [W-1:0] r;
    wr(2'd1, W'(p)); wr(2'd2, W'(d));
    wait_cyc(2*(p+2));
    rd(2'd2, r);
    check(r == W'(d), "R3 load", int'(r), d);
  endtask

  task automatic t_reset;
    logic [W-1:0] r;
    check(pwm_oe == 0, "R1 reset oe", int'(pwm_oe), 0);
    rd(2'd0, r); check(r == 0, "R10 reset status", int'(r), 0);
    check(irq == 0, "R11 reset flag", int'(irq), 0);
  endtask

  task automatic t_mode_gate;
    int h;
    tick = 1;
    wr(2'd0, 8'h03); set_duty(7, 4);
    count_high(16, h);
    check(h == 0 && pwm_oe == 0, "R1 idle mode quiet", h, 0);
    wr(2'd0, 8'h07); @(negedge clk);
    check(pwm_oe == 1, "R1 pwm mode oe", int'(pwm_oe), 1);
  endtask

  task automatic t_period;
    int n = 0;
    set_duty(5, 2);
    while (!pwm_out) @(negedge clk);
    while (pwm_out) @(negedge clk);
    while (!pwm_out) begin @(negedge clk); n++; end
    check(n == 4, "R2 low stretch", n, 4);
    n = 0;
    while (pwm_out) begin @(negedge clk); n++; end
    check(n == 2, "R7 high stretch", n, 2);
  endtask

  task automatic t_duty_cases;
    int h;
    set_duty(7, 3); count_high(24, h); check(h == 9, "R7 duty 3/8", h, 9);
    set_duty(7, 0); count_high(24, h); check(h == 0, "R4 zero duty", h, 0);
    set_duty(7, 9); count_high(24, h); check(h == 24, "R5 over-period duty", h, 24);
    set_duty(7, 7); count_high(24, h); check(h == 21, "R6 equal duty", h, 21);
  endtask

  task automatic t_buffer;
    logic [W-1:0] r;
    tick = 0;
    wr(2'd2, 8'd2); rd(2'd2, r);
    check(r == 8'd7, "R3 shadow not active", int'(r), 7);
    wait_cyc(5); rd(2'd2, r);
    check(r == 8'd7, "R3 held without wrap", int'(r), 7);
    tick = 1; wait_cyc(10); rd(2'd2, r);
    check(r == 8'd2, "R3 applied at wrap", int'(r), 2);
  endtask

  task automatic t_fault;
    logic [W-1:0] r;
    @(negedge clk); #2; fault_n = 0; #1;
    check(pwm_oe == 0, "R8 async hiz", int'(pwm_oe), 0);
    wait_cyc(5); rd(2'd0, r);
    check(r[3] == 1, "R10 status set", int'(r[3]), 1);
    check(irq == 1, "R11 flag set", int'(irq), 1);
    wr(2'd0, 8'h07); rd(2'd0, r);
    check(r[3] == 1, "R9 rewrite under fault keeps", int'(r[3]), 1);
    fault_n = 1; wait_cyc(5);
    check(pwm_oe == 0, "R9 latched after release", int'(pwm_oe), 0);
    wr(2'd0, 8'h07); rd(2'd0, r);
    check(r[3] == 0, "R10 status cleared", int'(r[3]), 0);
    check(pwm_oe == 1, "R9 oe restored", int'(pwm_oe), 1);
    wr(2'd3, 8'h00);
    check(irq == 1, "R11 write 0 ignored", int'(irq), 1);
    wr(2'd3, 8'h01);
    check(irq == 0, "R11 write 1 clears", int'(irq), 0);
  endtask

  task automatic t_fault_idle;
    logic [W-1:0] r;
    wr(2'd0, 8'h00);
    fault_n = 0; wait_cyc(6); fault_n = 1; wait_cyc(4);
    rd(2'd0, r);
    check(r[3] == 0, "R12 no status idle", int'(r[3]), 0);
    check(irq == 0, "R12 no flag idle", int'(irq), 0);
  endtask

  initial begin
    wait_cyc(3); #1; t_reset();
    rst_n = 1;
    t_mode_gate();
    t_period();
    t_duty_cases();
    t_buffer();
    t_fault();
    t_fault_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule